// File: doc/BRIEF.md
# Spread-Spectrum Switching Period Selector

This block sets the length of every cycle of a switching regulator's timebase so that the switching frequency hops between sixteen evenly spaced bins. A 4-bit pseudo-random code picks the bin. Bin k runs at 2.00 MHz + k x 40 kHz, so the range is 2.00 MHz to 2.60 MHz. The code sequence visits all sixteen values, zero included, exactly once in every sixteen spread periods. Each bin therefore carries the same share of the emitted energy.

Each cycle is counted out on a reference clock, 208 MHz by default. The period count comes from a table of rounded values that is computed at elaboration. The switch-on gate is held high for the first part of each period. Its length is the period count scaled by an 8-bit duty fraction, so the duty ratio stays the same while the period hops. The code, the duty fraction and the spread/base choice are taken only at a period boundary, so no cycle is cut short. When the converter is locked to an external clock, or when a debug flag is set, spreading stops. Every period then uses the base bin, and the sequence resumes where it stopped once both flags clear.

Top module: `ss_period_select`

## Requirements
- R1: A synchronous reset restarts the code sequence at 0000 and clears the timer. While reset is high, `bin_code` reads 0, and `sw_gate` and `period_end` are low.
- R2: With spreading active, successive periods use the codes 0,1,2,4,9,3,6,13,10,5,11,7,15,14,12,8 (decimal) in that order and then repeat, so each code appears exactly once per 16 periods.
- R3: A period with code k lasts round(208000 / (2000 + 40k)) reference cycles: 104 cycles for code 0 and 80 cycles for code 15. `period_end` is high only in the last cycle of the period.
- R4: `sw_gate` is high for the first floor(P x D / 256) cycles of each period and low for the rest, where P is the period count and D is the 8-bit duty fraction. A duty of 0 gives no gate, and a duty of 255 leaves at least one cycle low.
- R5: `bin_code` changes only at a period boundary and stays stable for the whole period.
- R6: If `ext_lock` or `debug_mode` is high at a boundary, the next period uses code 0 and lasts 104 cycles, and the code sequence does not advance. When both flags are low again at a boundary, the sequence continues with the code that would have come next.
- R7: A change of `duty_frac` during a period takes effect from the next period. The gate length of the current period is not changed.
- R8: One cycle after `enable` goes low, `sw_gate` and `period_end` stay low and the timer is cleared. The code held at that point is kept. Raising `enable` again starts a full-length period with that same code, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that counts out each period |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the period timer when high |
| duty_frac | input | DUTY_W (8) | Requested on fraction in units of 1/256 |
| ext_lock | input | 1 | High while an external clock controls switching; forces the base bin |
| debug_mode | input | 1 | Forces the base bin when high |
| period_end | output | 1 | High in the last cycle of each period |
| sw_gate | output | 1 | Switch-on gate for the current period |
| bin_code | output | CODE_W (4) | Frequency bin code of the current period |

## Verification
The bench runs a full sweep of seventeen periods. A code generator that skipped the inserted zero state, or repeated a code, shows up there as a wrong order or an uneven count of codes. Extreme and odd duty fractions test the scaling: a product truncated to the wrong bits would give a gate that is too long, or one that covers the whole period at full duty. A duty change and a bypass request are each made partway through a period. A design that sampled them at once would shorten the current gate or period, and one that let the sequence run during bypass would resume at the wrong code. Dropping `enable` mid-period checks that the gate dies at once and that the restart keeps its code and runs a full-length period.

// File: rtl/ss_pkg.sv
package ss_pkg;

  // Rounded reference-clock count for one period of bin `code`.
  function automatic int unsigned bin_period(input int unsigned ref_khz,
                                             input int unsigned base_khz,
                                             input int unsigned step_khz,
                                             input int unsigned code);
    int unsigned f;
    f = base_khz + step_khz * code;
    return (ref_khz + f / 2) / f;
  endfunction

  // Feedback tap mask for a maximal-length Fibonacci LFSR, shift-left form.
  function automatic int unsigned lfsr_taps(input int unsigned width);
    case (width)
      2:       return 32'h3;
      3:       return 32'h6;
      4:       return 32'hC;
      5:       return 32'h14;
      6:       return 32'h30;
      default: return 32'hC;
    endcase
  endfunction

endpackage

// File: rtl/ss_code_gen.sv
module ss_code_gen #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [CODE_W-1:0] TAPS = CODE_W'(ss_pkg::lfsr_taps(CODE_W));

  logic              feedback;
  logic              low_zero;
  logic [CODE_W-1:0] code_nxt;

  // The all-zero state is inserted after 100..0 so the period is 2^CODE_W.
  assign low_zero = (code_q[CODE_W-2:0] == '0);
  assign feedback = (^(code_q & TAPS)) ^ low_zero;
  assign code_nxt = {code_q[CODE_W-2:0], feedback};

  always_ff @(posedge clk) begin
    if (rst)          code_q <= '0;
    else if (advance) code_q <= code_nxt;
  end

  a_r1_reset_seed: assert property (@(posedge clk) rst |=> code_q == '0);

  a_r5_code_held: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(code_q));

  a_r2_code_moves: assert property (@(posedge clk) disable iff (rst)
    advance |=> code_q != $past(code_q));

  a_r2_zero_exit: assert property (@(posedge clk) disable iff (rst)
    (advance && code_q == '0) |=> code_q == CODE_W'(1));

endmodule

// File: rtl/ss_period_table.sv
module ss_period_table #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned REF_KHZ  = 208000,
  parameter int unsigned BASE_KHZ = 2000,
  parameter int unsigned STEP_KHZ = 40
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  period
);
  localparam int unsigned NBINS = 1 << CODE_W;

  logic [CNT_W-1:0] table_q [NBINS];

  for (genvar k = 0; k < NBINS; k++) begin : g_bin
    assign table_q[k] = CNT_W'(ss_pkg::bin_period(REF_KHZ, BASE_KHZ, STEP_KHZ, k));
  end

  assign period = table_q[code];

endmodule

// File: rtl/ss_duty_scale.sv
module ss_duty_scale #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned DUTY_W = 8
) (
  input  logic [CNT_W-1:0]  period,
  input  logic [DUTY_W-1:0] duty,
  output logic [CNT_W-1:0]  on_cnt
);
  localparam int unsigned PW = CNT_W + DUTY_W;

  // The top CNT_W bits of the product give the floor of P * D / 2^DUTY_W.
  assign on_cnt = CNT_W'((PW'(period) * PW'(duty)) >> DUTY_W);

endmodule

// File: rtl/ss_period_timer.sv
module ss_period_timer #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] on_cnt,
  output logic             period_end,
  output logic             gate
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last       = (cnt == period - 1'b1);
  assign period_end = run && last;
  assign gate       = run && (cnt < on_cnt);

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt < period);

  a_r4_gate_low_at_end: assert property (@(posedge clk) disable iff (rst)
    period_end |-> !gate);

  a_r8_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);

endmodule

// File: rtl/ss_period_select.sv
module ss_period_select #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned DUTY_W   = 8,
  parameter int unsigned REF_KHZ  = 208000,
  parameter int unsigned BASE_KHZ = 2000,
  parameter int unsigned STEP_KHZ = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DUTY_W-1:0] duty_frac,
  input  logic              ext_lock,
  input  logic              debug_mode,
  output logic              period_end,
  output logic              sw_gate,
  output logic [CODE_W-1:0] bin_code
);
  localparam int unsigned MAX_PER = ss_pkg::bin_period(REF_KHZ, BASE_KHZ, STEP_KHZ, 0);
  localparam int unsigned CNT_W   = $clog2(MAX_PER + 1);

  logic              en_q;
  logic              byp_q;
  logic [DUTY_W-1:0] duty_q;
  logic              boundary;
  logic              code_adv;
  logic [CODE_W-1:0] lfsr_code;
  logic [CNT_W-1:0]  per_w;
  logic [CNT_W-1:0]  on_w;
  logic              pe_w;
  logic              gate_w;

  // Period settings are taken while idle or at the end of a period.
  assign boundary = !en_q || pe_w;
  assign code_adv = pe_w && !byp_q;
  assign bin_code = byp_q ? '0 : lfsr_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      byp_q  <= 1'b0;
      duty_q <= '0;
    end else begin
      en_q <= enable;
      if (boundary) begin
        byp_q  <= ext_lock | debug_mode;
        duty_q <= duty_frac;
      end
    end
  end

  ss_code_gen #(.CODE_W(CODE_W)) u_code (
    .clk     (clk),
    .rst     (rst),
    .advance (code_adv),
    .code_q  (lfsr_code)
  );

  ss_period_table #(
    .CODE_W   (CODE_W),
    .CNT_W    (CNT_W),
    .REF_KHZ  (REF_KHZ),
    .BASE_KHZ (BASE_KHZ),
    .STEP_KHZ (STEP_KHZ)
  ) u_table (
    .code   (bin_code),
    .period (per_w)
  );

  ss_duty_scale #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_scale (
    .period (per_w),
    .duty   (duty_q),
    .on_cnt (on_w)
  );

  ss_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (en_q),
    .period     (per_w),
    .on_cnt     (on_w),
    .period_end (pe_w),
    .gate       (gate_w)
  );

  assign period_end = pe_w;
  assign sw_gate    = gate_w;

  a_r6_base_period: assert property (@(posedge clk) disable iff (rst)
    byp_q |-> per_w == CNT_W'(MAX_PER));

  a_r6_sequence_frozen: assert property (@(posedge clk) disable iff (rst)
    byp_q |=> $stable(lfsr_code));

  a_r7_duty_held: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(duty_q));

endmodule

// File: tb/ss_period_select_bench.sv
module ss_period_select_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] SEQ [16] = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd9, 4'd3, 4'd6, 4'd13,
                                       4'd10, 4'd5, 4'd11, 4'd7, 4'd15, 4'd14, 4'd12, 4'd8};
  localparam logic [7:0] DUTY_VEC [6] = '{8'd0, 8'd255, 8'd64, 8'd200, 8'd1, 8'd128};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [7:0] duty = 8'd128;
  logic       ext_lock = 1'b0;
  logic       debug_mode = 1'b0;
  logic       period_end;
  logic       sw_gate;
  logic [3:0] bin_code;

  int checks = 0;
  int fails  = 0;
  int pos    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ss_period_select u_ss_period_select (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .duty_frac  (duty),
    .ext_lock   (ext_lock),
    .debug_mode (debug_mode),
    .period_end (period_end),
    .sw_gate    (sw_gate),
    .bin_code   (bin_code)
  );

  function automatic int exp_len(input int k);
    real f;
    f = 2.0e6 + 40.0e3 * k;
    return $rtoi(208.0e6 / f + 0.5);
  endfunction

  function automatic int exp_on(input int len, input int d);
    return (len * d) / 256;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Samples one period at negedges; optionally changes inputs at sample chg_at.
  task automatic take_period(input int chg_at, input logic [7:0] nd, input logic nl,
                             input logic ndb, output int len, output int on,
                             output logic [3:0] c0, output bit stable, output bit contig);
    bit dropped;
    len = 0; on = 0; stable = 1'b1; contig = 1'b1; dropped = 1'b0; c0 = '0;
    while (len < 400) begin
      @(negedge clk);
      if (len == 0) c0 = bin_code;
      else if (bin_code != c0) stable = 1'b0;
      len++;
      if (sw_gate) begin
        on++;
        if (dropped) contig = 1'b0;
      end else begin
        dropped = 1'b1;
      end
      if (len == chg_at) begin
        duty = nd; ext_lock = nl; debug_mode = ndb;
      end
      if (period_end) break;
    end
  endtask

  task automatic check_period(input logic [3:0] ec, input int ed, input bit spread,
                              input int chg_at, input logic [7:0] nd, input logic nl,
                              input logic ndb, input string req);
    int len, on;
    logic [3:0] c0;
    bit stable, contig;
    take_period(chg_at, nd, nl, ndb, len, on, c0, stable, contig);
    chk(c0 == ec, req, "bin code", c0, ec);
    chk(len == exp_len(ec), req, "period length (R3)", len, exp_len(ec));
    chk(on == exp_on(len, ed), req, "gate cycles (R4)", on, exp_on(len, ed));
    chk(contig, req, "gate contiguous at period start (R4)", contig, 1);
    chk(stable, req, "code stable within period (R5)", stable, 1);
    if (spread) pos++;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hits [16];
    for (int k = 0; k < 16; k++) hits[k] = 0;

    // R1: state during reset
    repeat (4) @(negedge clk);
    chk(bin_code == 4'd0, "R1", "code in reset", bin_code, 0);
    chk(!sw_gate, "R1", "gate in reset", sw_gate, 0);
    chk(!period_end, "R1", "period end in reset", period_end, 0);
    rst = 1'b0;

    // R8: idle before enable
    repeat (3) @(negedge clk);
    chk(!sw_gate && !period_end, "R8", "idle outputs", {sw_gate, period_end}, 0);

    // R2/R3/R4/R5: full spread sweep, table walked by one loop
    enable = 1'b1;
    for (int i = 0; i < 17; i++) begin
      if (i < 16) hits[SEQ[i]]++;
      check_period(SEQ[pos % 16], 128, 1'b1, -1, duty, 1'b0, 1'b0, "R2");
    end
    for (int k = 0; k < 16; k++) chk(hits[k] == 1, "R2", "uses per code", hits[k], 1);

    // R4: duty vectors
    for (int j = 0; j < 6; j++) begin
      duty = DUTY_VEC[j];
      check_period(SEQ[pos % 16], DUTY_VEC[j], 1'b1, -1, duty, 1'b0, 1'b0, "R4");
    end

    // R7: mid-period duty change
    check_period(SEQ[pos % 16], 128, 1'b1, 5, 8'd32, 1'b0, 1'b0, "R7");
    check_period(SEQ[pos % 16], 32, 1'b1, -1, 8'd32, 1'b0, 1'b0, "R7");

    // R6: external lock requested mid-period, then released
    check_period(SEQ[pos % 16], 32, 1'b1, 3, 8'd32, 1'b1, 1'b0, "R6");
    check_period(4'd0, 32, 1'b0, -1, 8'd32, 1'b1, 1'b0, "R6");
    check_period(4'd0, 32, 1'b0, 3, 8'd32, 1'b0, 1'b0, "R6");
    check_period(SEQ[pos % 16], 32, 1'b1, -1, 8'd32, 1'b0, 1'b0, "R6");

    // R6: debug flag behaves the same
    check_period(SEQ[pos % 16], 32, 1'b1, 2, 8'd200, 1'b0, 1'b1, "R6");
    check_period(4'd0, 200, 1'b0, 2, 8'd200, 1'b0, 1'b0, "R6");
    check_period(SEQ[pos % 16], 200, 1'b1, -1, 8'd200, 1'b0, 1'b0, "R6");

    // R8: drop enable mid-period, code held, full restart
    repeat (10) @(negedge clk);
    enable = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      chk(!sw_gate && !period_end, "R8", "outputs while disabled", {sw_gate, period_end}, 0);
      chk(bin_code == SEQ[pos % 16], "R8", "code held while disabled", bin_code, SEQ[pos % 16]);
    end
    enable = 1'b1;
    check_period(SEQ[pos % 16], 200, 1'b1, -1, 8'd200, 1'b0, 1'b0, "R8");
    check_period(SEQ[pos % 16], 200, 1'b1, -1, 8'd200, 1'b0, 1'b0, "R8");

    // R1: reset mid-run restarts at code 0
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(bin_code == 4'd0 && !sw_gate, "R1", "state after mid-run reset", bin_code, 0);
    rst = 1'b0;
    pos = 0;
    check_period(SEQ[0], 200, 1'b1, -1, 8'd200, 1'b0, 1'b0, "R1");
    check_period(SEQ[1], 200, 1'b1, -1, 8'd200, 1'b0, 1'b0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule